// File: doc/BRIEF.md
# Descriptor DMA Command Sequencer

This block walks a ring of command descriptors kept in a word-addressed memory. Each descriptor names an operation, a data address, a requested byte count, a branch target and three 2-bit condition codes. For each one the sequencer fetches the descriptor and decodes its opcode. It then carries out the transfer: bytes go out on a valid/ready output stream, come in on a valid/ready input stream, or a single 32-bit word moves to or from an internal holding register. After the transfer it writes a completion word back into the descriptor.

Three selectors are presented as inputs, one each for interrupt, branch and wait. Each selector is a mask and a match byte that are compared against the eight device status bits. Each descriptor's codes decide from these compares whether it pulses the interrupt line, whether it jumps to its branch target, and whether it holds before moving on. A run input starts fetching. A stop descriptor parks the sequencer until run is dropped.

Top module: `desc_dma_seq`

## Requirements
- R1: While reset is held and immediately after it, `active` is 0, `cur_idx` is 0, `irq` is 0, and no memory read or write is issued. Fetching starts from the idle state only when `run` is 1.
- R2: Descriptor k occupies words 4k..4k+3. Word 0 holds the opcode in [2:0], the interrupt code in [5:4], the branch code in [7:6], the wait code in [9:8] and the byte count in [31:16]. Word 1 holds the data word address. Word 2 holds the branch target index in its low bits. Word 3 receives the completion word.
- R3: Opcodes 0 (send, more follows) and 1 (send, final) read the requested bytes from the data address, least significant byte of each word first, and present them on `out_data`. `out_last` is 1 only on the final byte of opcode 1. While `out_valid` is 1 and `out_ready` is 0, the byte is held unchanged.
- R4: Opcodes 2 (receive, more follows) and 3 (receive, final) store each accepted input byte at data address + n/4, in byte lane n mod 4, where n is the byte number. Opcode 2 ignores `in_last` and always takes the full count.
- R5: Opcode 3 also ends when a byte arrives with `in_last` set. The residual written back is then the count minus the bytes received.
- R6: Opcode 5 loads the word at the data address into an internal register. Opcode 4 writes that register to the data address with all four byte enables. Either one counts four bytes moved.
- R7: A selector condition is true when (`dev_status` AND mask) equals match. A code of 0 never applies, 1 applies when the condition is true, 2 applies when it is false, and 3 always applies.
- R8: `irq` is high for exactly the cycle of the completion write when the interrupt code applies, and never at any other time.
- R9: When the branch code applies, the next index is the branch target. Otherwise the index advances by one and wraps from N_DESC-1 to 0. The index changes only in the cycle after a completion write.
- R10: After the transfer, the sequencer holds, with no completion write, for as long as the wait code applies. It re-evaluates the wait condition every cycle.
- R11: The completion word carries the residual (count minus bytes moved) in [31:16] and the status in [15:0]. In the status, bit 15 = `run`, bit 10 = 1, bit 8 = branch taken, [7:0] = `dev_status`, and the other bits are 0.
- R12: Opcode 7 moves no data and writes nothing back. It drops `active` and leaves `cur_idx` on the stop descriptor until `run` goes low.
- R13: Opcode 6 moves no data. Its residual equals its count, and its conditions are applied as for any other descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Start fetching; stop-parked sequencer resumes after it drops |
| dev_status | input | 8 | Device status bits |
| int_mask | input | 8 | Interrupt selector mask |
| int_match | input | 8 | Interrupt selector match value |
| br_mask | input | 8 | Branch selector mask |
| br_match | input | 8 | Branch selector match value |
| wt_mask | input | 8 | Wait selector mask |
| wt_match | input | 8 | Wait selector match value |
| mem_addr | output | ADDR_W | Memory word address |
| mem_rd | output | 1 | Read strobe; data returns on mem_rdata one cycle later |
| mem_wr | output | 1 | Write strobe |
| mem_be | output | 4 | Byte enables for a write |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Output byte accepted |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Final byte of a send-final command |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Sequencer accepts input bytes |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | End of packet marker |
| irq | output | 1 | Interrupt pulse |
| cur_idx | output | $clog2(N_DESC) | Current descriptor index |
| active | output | 1 | A descriptor is being processed |

## Verification
Memory returns read data one cycle after `mem_rd`. The first output byte therefore appears six cycles after the sequencer leaves idle: three descriptor reads, a decode cycle, a data read and a latch cycle. The completion write comes at the earliest two cycles after the last byte or word moves. `irq` is due in that same cycle. After the wait condition clears, the completion write follows one cycle later. Rather than count these cycles directly, the bench queues the expected completion words and output bytes in order. A monitor samples at the falling edge, when a write strobe or a byte handshake is actually present, and pops and compares the next expected item. The wait hold and the final stop are checked against fixed cycle windows that are longer than the worst-case path.

// File: rtl/desc_dma_seq.sv
module desc_dma_seq #(
  parameter int N_DESC = 8,
  parameter int ADDR_W = 8,
  localparam int IDX_W = $clog2(N_DESC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [7:0]        dev_status,
  input  logic [7:0]        int_mask,
  input  logic [7:0]        int_match,
  input  logic [7:0]        br_mask,
  input  logic [7:0]        br_match,
  input  logic [7:0]        wt_mask,
  input  logic [7:0]        wt_match,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [3:0]        mem_be,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [7:0]        out_data,
  output logic              out_last,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_data,
  input  logic              in_last,
  output logic              irq,
  output logic [IDX_W-1:0]  cur_idx,
  output logic              active
);

  typedef enum logic [3:0] {
    S_IDLE, S_HALT, S_RD0, S_RD1, S_RD2, S_DEC, S_ORD, S_OLAT,
    S_OSEND, S_IN, S_QRD, S_QLAT, S_QWR, S_WAIT, S_WB
  } st_t;

  st_t              st;
  logic [2:0]       op;
  logic [1:0]       c_int, c_br, c_wt;
  logic [15:0]      cnt, moved;
  logic [ADDR_W-1:0] daddr;
  logic [IDX_W-1:0] tgt;
  logic [31:0]      obuf, quad;

  function automatic logic applies(input logic [1:0] code, input logic cond);
    return (code == 2'd3) || (code == 2'd1 && cond) || (code == 2'd2 && !cond);
  endfunction

  wire int_dec = applies(c_int, (dev_status & int_mask) == int_match);
  wire br_dec  = applies(c_br,  (dev_status & br_mask)  == br_match);
  wire wt_dec  = applies(c_wt,  (dev_status & wt_mask)  == wt_match);

  wire [ADDR_W-1:0] base  = ADDR_W'({cur_idx, 2'b00});
  wire [ADDR_W-1:0] woff  = ADDR_W'(moved >> 2);
  wire [1:0]        lane  = moved[1:0];
  wire              lastb = (moved + 16'd1 == cnt);
  wire [15:0]       resid = cnt - moved;
  wire [15:0]       stat  = {run, 4'b0000, 1'b1, 1'b0, br_dec, dev_status};
  wire              in_end = lastb || (op == 3'd3 && in_last);

  assign active    = !(st == S_IDLE || st == S_HALT);
  assign irq       = (st == S_WB) && int_dec;
  assign mem_rd    = (st == S_RD0) || (st == S_RD1) || (st == S_RD2) || (st == S_ORD) || (st == S_QRD);
  assign mem_wr    = (st == S_IN && in_valid) || (st == S_QWR) || (st == S_WB);
  assign mem_be    = (st == S_IN) ? (4'b0001 << lane) : 4'hF;
  assign out_valid = (st == S_OSEND);
  assign out_data  = obuf[{lane, 3'b000} +: 8];
  assign out_last  = (st == S_OSEND) && (op == 3'd1) && lastb;
  assign in_ready  = (st == S_IN);

  always_comb begin
    case (st)
      S_RD1:                  mem_addr = base + ADDR_W'(1);
      S_RD2:                  mem_addr = base + ADDR_W'(2);
      S_WB:                   mem_addr = base + ADDR_W'(3);
      S_ORD, S_IN, S_QRD, S_QWR: mem_addr = daddr + woff;
      default:                mem_addr = base;
    endcase
    case (st)
      S_IN:    mem_wdata = {4{in_data}};
      S_QWR:   mem_wdata = quad;
      default: mem_wdata = {resid, stat};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; cur_idx <= '0; op <= '0; c_int <= '0; c_br <= '0; c_wt <= '0;
      cnt <= '0; moved <= '0; daddr <= '0; tgt <= '0; obuf <= '0; quad <= '0;
    end else begin
      case (st)
        S_IDLE: if (run) st <= S_RD0;
        S_HALT: if (!run) st <= S_IDLE;
        S_RD0: begin moved <= '0; st <= S_RD1; end
        S_RD1: begin
          op <= mem_rdata[2:0]; c_int <= mem_rdata[5:4]; c_br <= mem_rdata[7:6];
          c_wt <= mem_rdata[9:8]; cnt <= mem_rdata[31:16]; st <= S_RD2;
        end
        S_RD2: begin daddr <= mem_rdata[ADDR_W-1:0]; st <= S_DEC; end
        S_DEC: begin
          tgt <= mem_rdata[IDX_W-1:0];
          case (op)
            3'd0, 3'd1: st <= (cnt == 16'd0) ? S_WAIT : S_ORD;
            3'd2, 3'd3: st <= (cnt == 16'd0) ? S_WAIT : S_IN;
            3'd4:       st <= S_QWR;
            3'd5:       st <= S_QRD;
            3'd6:       st <= S_WAIT;
            default:    st <= S_HALT;
          endcase
        end
        S_ORD:  st <= S_OLAT;
        S_OLAT: begin obuf <= mem_rdata; st <= S_OSEND; end
        S_OSEND: if (out_ready) begin
          moved <= moved + 16'd1;
          if (lastb) st <= S_WAIT;
          else if (lane == 2'd3) st <= S_ORD;
        end
        S_IN: if (in_valid) begin
          moved <= moved + 16'd1;
          if (in_end) st <= S_WAIT;
        end
        S_QRD:  st <= S_QLAT;
        S_QLAT: begin quad <= mem_rdata; moved <= 16'd4; st <= S_WAIT; end
        S_QWR:  begin moved <= 16'd4; st <= S_WAIT; end
        S_WAIT: if (!wt_dec) st <= S_WB;
        S_WB: begin
          if (br_dec) cur_idx <= tgt;
          else if (cur_idx == IDX_W'(N_DESC - 1)) cur_idx <= '0;
          else cur_idx <= cur_idx + IDX_W'(1);
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

module desc_dma_seq_chk #(
  parameter int N_DESC = 8,
  parameter int ADDR_W = 8,
  localparam int IDX_W = $clog2(N_DESC)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              active,
  input logic              irq,
  input logic [IDX_W-1:0]  cur_idx,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [3:0]        mem_be,
  input logic              out_valid,
  input logic              out_ready,
  input logic [7:0]        out_data,
  input logic              in_ready
);
  AST_IRQ_AT_WRITEBACK: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (mem_wr && mem_be == 4'hF && mem_addr[1:0] == 2'd3)); // R8
  AST_QUIET_WHEN_INACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (!mem_rd && !mem_wr && !out_valid && !in_ready)); // R12
  AST_IDX_AFTER_WRITEBACK: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cur_idx) |-> $past(mem_wr && mem_addr[1:0] == 2'd3)); // R9
  AST_IDX_IN_RING: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, cur_idx} < (IDX_W + 1)'(N_DESC)); // R9
  AST_OUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R3
  AST_ONE_DIRECTION: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && in_ready)); // R4
endmodule

bind desc_dma_seq desc_dma_seq_chk #(.N_DESC(N_DESC), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/desc_dma_seq_test.sv
module desc_dma_seq_test;
  logic clk = 0, rst_n = 0, run = 0;
  logic [7:0] dev_status = 8'h35;
  logic [7:0] int_mask = 8'h03, int_match = 8'h01;
  logic [7:0] br_mask = 8'h0F, br_match = 8'h05;
  logic [7:0] wt_mask = 8'h80, wt_match = 8'h80;
  logic [7:0] mem_addr;
  logic mem_rd, mem_wr, out_valid, out_ready, out_last, in_valid, in_ready, in_last, irq, active;
  logic [3:0] mem_be;
  logic [31:0] mem_wdata, mem_rdata;
  logic [7:0] out_data, in_data;
  logic [2:0] cur_idx;

  always #2 clk = ~clk;

  desc_dma_seq uut (.*);

  logic [31:0] mem [0:255];
  logic patch_en = 0; logic [7:0] patch_addr = 0; logic [31:0] patch_data = 0;
  always @(posedge clk) begin
    if (patch_en) mem[patch_addr] <= patch_data;
    else if (mem_wr)
      for (int b = 0; b < 4; b++) if (mem_be[b]) mem[mem_addr][8*b +: 8] <= mem_wdata[8*b +: 8];
    if (mem_rd) mem_rdata <= mem[mem_addr];
  end

  logic [1:0] rdy_cnt = 0;
  always @(posedge clk) rdy_cnt <= rdy_cnt + 2'd1;
  assign out_ready = (rdy_cnt != 2'b11);

  logic [7:0] in_bytes [0:8] = '{8'hA0, 8'hA1, 8'hA2, 8'hA3, 8'hA4, 8'hA5, 8'hB0, 8'hB1, 8'hB2};
  logic       in_lasts [0:8] = '{0, 0, 1, 0, 0, 0, 0, 0, 1};
  int in_ptr = 0;
  always @(posedge clk) if (in_valid && in_ready) in_ptr <= in_ptr + 1;
  assign in_valid = (in_ptr < 9);
  assign in_data  = (in_ptr < 9) ? in_bytes[in_ptr] : 8'h00;
  assign in_last  = (in_ptr < 9) ? in_lasts[in_ptr] : 1'b0;

  int n_cmp = 0, n_bad = 0, wb_seen = 0;
  logic [40:0] wbq [$];
  logic [8:0]  outq [$];

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic poke(input logic [7:0] a, input logic [31:0] d);
    patch_addr = a; patch_data = d; patch_en = 1;
    @(posedge clk); #1 patch_en = 0;
  endtask

  function automatic logic [31:0] w0(input logic [2:0] op, input logic [1:0] ic, bc, wc, input logic [15:0] c);
    return {c, 6'b0, wc, bc, ic, 1'b0, op};
  endfunction

  // monitor: completion writes (R11, R8, R9) and output bytes (R3)
  always @(negedge clk) if (rst_n) begin
    if (mem_wr && mem_addr < 8'd32) begin
      wb_seen++;
      if (wbq.size() == 0) check("R11 unexpected writeback", {23'b0, irq, mem_addr, mem_wdata}, 64'h0);
      else check("R11/R8/R9 completion word", {23'b0, irq, mem_addr, mem_wdata}, {23'b0, wbq.pop_front()});
    end else if (irq) check("R8 irq outside writeback", 64'd1, 64'd0);
    if (out_valid && out_ready) begin
      if (outq.size() == 0) check("R3 unexpected byte", {55'b0, out_last, out_data}, 64'h0);
      else check("R3 output byte", {55'b0, out_last, out_data}, {55'b0, outq.pop_front()});
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    // descriptor layout per R2
    poke(0,  w0(3'd0, 2'd0, 2'd0, 2'd0, 16'd5)); poke(1, 32'd64); poke(2, 32'd0);
    poke(4,  w0(3'd1, 2'd3, 2'd2, 2'd0, 16'd3)); poke(5, 32'd66); poke(6, 32'd0);
    poke(8,  w0(3'd2, 2'd0, 2'd0, 2'd0, 16'd6)); poke(9, 32'd80); poke(10, 32'd0);
    poke(12, w0(3'd3, 2'd1, 2'd0, 2'd0, 16'd8)); poke(13, 32'd84); poke(14, 32'd0);
    poke(16, w0(3'd5, 2'd0, 2'd0, 2'd0, 16'd4)); poke(17, 32'd64); poke(18, 32'd0);
    poke(20, w0(3'd6, 2'd2, 2'd1, 2'd1, 16'd0)); poke(21, 32'd0);  poke(22, 32'd7); // R13 nop, branch to 7
    poke(24, w0(3'd7, 2'd0, 2'd0, 2'd0, 16'd0)); poke(25, 32'd0);  poke(26, 32'd0);
    poke(28, w0(3'd4, 2'd0, 2'd0, 2'd2, 16'd4)); poke(29, 32'd90); poke(30, 32'd0);
    poke(64, 32'h44332211); poke(65, 32'h88776655); poke(66, 32'hCCBBAA99);
    poke(80, 32'h0); poke(81, 32'h0); poke(84, 32'h0); poke(90, 32'h0);

    // expected completion words {irq, addr, {residual, status}}
    wbq.push_back({1'b0, 8'd3,  32'h0000_8435});
    wbq.push_back({1'b1, 8'd7,  32'h0000_8435});  // R7 code 3 always
    wbq.push_back({1'b0, 8'd11, 32'h0000_8435});
    wbq.push_back({1'b1, 8'd15, 32'h0005_8435});  // R5 residual 5, R7 code 1 true
    wbq.push_back({1'b0, 8'd19, 32'h0000_8435});  // R6
    wbq.push_back({1'b0, 8'd23, 32'h0000_8535});  // R13 nop, R9 branch bit 8
    wbq.push_back({1'b0, 8'd31, 32'h0000_84B5});  // R10 after release
    outq.push_back({1'b0, 8'h11}); outq.push_back({1'b0, 8'h22}); outq.push_back({1'b0, 8'h33});
    outq.push_back({1'b0, 8'h44}); outq.push_back({1'b0, 8'h55});
    outq.push_back({1'b0, 8'h99}); outq.push_back({1'b0, 8'hAA}); outq.push_back({1'b1, 8'hBB});

    @(negedge clk);
    check("R1 active in reset", {63'b0, active}, 64'd0);
    check("R1 index in reset", {61'b0, cur_idx}, 64'd0);
    check("R1 memory access in reset", {62'b0, mem_rd, mem_wr}, 64'd0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    check("R1 idle without run", {63'b0, active}, 64'd0);
    run = 1;

    wait (active && cur_idx == 3'd7);
    repeat (25) @(negedge clk);
    check("R10 wait holds index", {61'b0, cur_idx}, 64'd7);
    check("R10 wait holds active", {63'b0, active}, 64'd1);
    check("R10 no writeback while held", wb_seen, 64'd6);
    check("R6 store-quad data", mem[90], 32'h44332211);
    poke(0, w0(3'd7, 2'd0, 2'd0, 2'd0, 16'd0));
    @(negedge clk);
    dev_status = 8'hB5;

    repeat (40) @(negedge clk);
    check("R12 stop drops active", {63'b0, active}, 64'd0);
    check("R9 wrap then R12 index stays on stop", {61'b0, cur_idx}, 64'd0);
    check("R12 no writeback for stop", wb_seen, 64'd7);
    check("R11 all completions seen", wbq.size(), 64'd0);
    check("R3 all bytes seen", outq.size(), 64'd0);
    check("R4 receive word 0", mem[80], 32'hA3A2A1A0);
    check("R4 in_last ignored by opcode 2", mem[81], 32'h0000A5A4);
    check("R5 early end data", mem[84], 32'h00B2B1B0);
    check("R12 no access after stop", {62'b0, mem_rd, mem_wr}, 64'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule